// File: doc/BRIEF.md
# Cascaded Layer Blending Chain

This block composites several video planes into one or more output pipes through a chain of blending stages whose order is set at run time. Each stage takes a top pixel from one input plane and lays it over a bottom pixel. The bottom pixel comes from another stage that the configuration names, or from the stage's own background color when no lower stage is named. Following the bottom links from a head stage builds a linked list of layers. Inserting, removing or reordering a layer only changes the link fields; no pixel data is moved.

A narrow write port programs the per-stage fields:
- top source
- bottom source
- mode
- alpha mode
- global alpha
- background color
- owning output pipe

It also programs the per-output selection of the head stage. The chain is resolved combinationally, one level per stage. The selected stage results are registered once per valid pixel. A per-stage idle flag shows which stages are not part of any active chain, so stages can be recycled safely.

Top module: `layer_mix_chain`

## Requirements
- R1: After reset, every top select, bottom select, owner field and output select reads as 0xF. Every stage is in top-only mode (1) with global alpha mode (2), global alpha 255 and a black background. `out_valid`, `out_pix` and `out_clk_en` are zero and every `stage_idle` bit is 1.
- R2: A write takes effect at the clock edge where `wr_en` is high. `wr_addr[3:0]` names the instance and `wr_addr[7:4]` names the field, coded as follows:
  - 0: top select
  - 1: bottom select
  - 2: mode
  - 3: alpha mode
  - 4: global alpha
  - 5: background red/Cr
  - 6: background green/Y
  - 7: background blue/Cb
  - 8: owner pipe
  - 9: output select

  A write whose instance index is out of range for its field has no effect.
- R3: A stage whose top select is 0xF, or any value that is not a plane, has no top layer: it contributes alpha 0 and outputs its bottom layer.
- R4: In blend mode (3), a stage's bottom layer is the result of the stage named by its bottom select. If that select is 0xF, names the stage itself, or is out of range, the stage's background color is used. In top-only mode the background is always the bottom layer.
- R5: Each 12-bit component is (top·α + bottom·(255−α) + 127)/255, rounded down, with an 8-bit α.
- R6: Alpha mode 0 takes α from the selected plane's alpha input. Any other alpha mode value takes the stage's global alpha.
- R7: A background write carries a 10-bit component that is stored shifted left by 2 into the 12-bit background.
- R8: Output selection and output timing:
  - When `pix_valid` is high, each output captures the result of the stage named by its output select. A select of 0xF or out of range gives zero.
  - `out_valid` and `out_pix` update one clock later.
  - With `pix_valid` low, `out_valid` is 0 and `out_pix` holds.
- R9: Writing an output select with any value other than 0xF sets that output's `out_clk_en` bit. The bit stays set for the rest of operation; later writes of 0xF do not clear it.
- R10: A stage is marked busy when it is reachable from output o, through that output's select and then bottom links of blend-mode stages, and its owner field equals o. Every other stage reads idle.
- R11: Chains up to the full stage count are resolved correctly in any order of stage indices. A link cycle among stages yields a finite result with no combinational loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 8 | Field code [7:4], instance index [3:0] |
| wr_data | input | IN_COMP_W (10) | Write data, low bits used per field |
| pix_valid | input | 1 | Plane pixels valid this cycle |
| plane_pix | input | NUM_PLANES*36 | Plane pixels; plane 0 in low bits, each pixel {R,G,B} at 12 bits each |
| plane_alpha | input | NUM_PLANES*8 | Per-plane per-pixel alpha, plane 0 in low bits |
| out_valid | output | 1 | Output pixels valid |
| out_pix | output | NUM_OUTS*36 | Output pixels; output 0 in low bits, {R,G,B} |
| out_clk_en | output | NUM_OUTS | Sticky per-output clock enable |
| stage_idle | output | NUM_STAGES | Per-stage idle flag |

## Verification
The assertions assume that configuration is stable while a pixel is in flight only in the sense that a write and a pixel in the same cycle see the old settings. They assume nothing beyond this about legal chains: self links, cycles and out-of-range selects are all allowed inputs. The stimulus drives writes and pixels on the falling edge and keeps `wr_data` within 10 bits. It deliberately programs broken links, out-of-range instance indices and a two-stage link cycle so that the guarded corners are exercised rather than avoided. Expected pixels come from an arithmetic model of the chain that iterates once per stage, and each full alpha range is swept against it.

// File: rtl/mix_pkg.sv
package mix_pkg;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_NONE = 4'hF;

    typedef enum logic [3:0] {
        K_TOP    = 4'd0,
        K_BOT    = 4'd1,
        K_MODE   = 4'd2,
        K_AMODE  = 4'd3,
        K_GALPHA = 4'd4,
        K_BG_R   = 4'd5,
        K_BG_G   = 4'd6,
        K_BG_B   = 4'd7,
        K_OWNER  = 4'd8,
        K_MUX    = 4'd9
    } reg_kind_e;

    localparam logic [1:0] MODE_TOP_ONLY = 2'd1;
    localparam logic [1:0] MODE_MIX      = 2'd3;
    localparam logic [1:0] AMODE_PIXEL   = 2'd0;
    localparam logic [1:0] AMODE_GLOBAL  = 2'd2;

endpackage

// File: rtl/mix_cfg_regs.sv
module mix_cfg_regs
    import mix_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int NUM_OUTS   = 2,
    parameter int COMP_W     = 12,
    parameter int IN_COMP_W  = 10,
    parameter int ALPHA_W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [7:0]                            wr_addr,
    input  logic [IN_COMP_W-1:0]                  wr_data,
    output logic [NUM_STAGES-1:0][SEL_W-1:0]      top_sel,
    output logic [NUM_STAGES-1:0][SEL_W-1:0]      bot_sel,
    output logic [NUM_STAGES-1:0][SEL_W-1:0]      owner,
    output logic [NUM_STAGES-1:0][1:0]            mode,
    output logic [NUM_STAGES-1:0][1:0]            amode,
    output logic [NUM_STAGES-1:0][ALPHA_W-1:0]    galpha,
    output logic [NUM_STAGES-1:0][3*COMP_W-1:0]   bg_px,
    output logic [NUM_OUTS-1:0][SEL_W-1:0]        mux_sel,
    output logic [NUM_OUTS-1:0]                   clk_en
);

    localparam int PAD_W = COMP_W - IN_COMP_W;

    typedef struct packed {
        logic [NUM_STAGES-1:0][SEL_W-1:0]         top;
        logic [NUM_STAGES-1:0][SEL_W-1:0]         bot;
        logic [NUM_STAGES-1:0][SEL_W-1:0]         own;
        logic [NUM_STAGES-1:0][1:0]               mode;
        logic [NUM_STAGES-1:0][1:0]               amode;
        logic [NUM_STAGES-1:0][ALPHA_W-1:0]       galpha;
        logic [NUM_STAGES-1:0][2:0][COMP_W-1:0]   bg;
        logic [NUM_OUTS-1:0][SEL_W-1:0]           mux;
        logic [NUM_OUTS-1:0]                      cen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    function automatic cfg_t reset_cfg();
        cfg_t r;
        r = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            r.top[s]    = SEL_NONE;
            r.bot[s]    = SEL_NONE;
            r.own[s]    = SEL_NONE;
            r.mode[s]   = MODE_TOP_ONLY;
            r.amode[s]  = AMODE_GLOBAL;
            r.galpha[s] = '1;
        end
        for (int o = 0; o < NUM_OUTS; o++) begin
            r.mux[o] = SEL_NONE;
        end
        return r;
    endfunction

    always_comb begin
        reg_kind_e         kind;
        logic [SEL_W-1:0]  idx;
        logic [COMP_W-1:0] wide;
        cfg_d = cfg_q;
        kind  = reg_kind_e'(wr_addr[7:4]);
        idx   = wr_addr[3:0];
        wide  = {wr_data, {PAD_W{1'b0}}};
        if (wr_en) begin
            for (int s = 0; s < NUM_STAGES; s++) begin
                if (idx == SEL_W'(s)) begin
                    case (kind)
                        K_TOP:    cfg_d.top[s]    = wr_data[SEL_W-1:0];
                        K_BOT:    cfg_d.bot[s]    = wr_data[SEL_W-1:0];
                        K_MODE:   cfg_d.mode[s]   = wr_data[1:0];
                        K_AMODE:  cfg_d.amode[s]  = wr_data[1:0];
                        K_GALPHA: cfg_d.galpha[s] = wr_data[ALPHA_W-1:0];
                        K_BG_R:   cfg_d.bg[s][2]  = wide;
                        K_BG_G:   cfg_d.bg[s][1]  = wide;
                        K_BG_B:   cfg_d.bg[s][0]  = wide;
                        K_OWNER:  cfg_d.own[s]    = wr_data[SEL_W-1:0];
                        default: ;
                    endcase
                end
            end
            for (int o = 0; o < NUM_OUTS; o++) begin
                if (kind == K_MUX && idx == SEL_W'(o)) begin
                    cfg_d.mux[o] = wr_data[SEL_W-1:0];
                    if (wr_data[SEL_W-1:0] != SEL_NONE) begin
                        cfg_d.cen[o] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= reset_cfg();
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign top_sel = cfg_q.top;
    assign bot_sel = cfg_q.bot;
    assign owner   = cfg_q.own;
    assign mode    = cfg_q.mode;
    assign amode   = cfg_q.amode;
    assign galpha  = cfg_q.galpha;
    assign bg_px   = cfg_q.bg;
    assign mux_sel = cfg_q.mux;
    assign clk_en  = cfg_q.cen;

    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_cen_chk
        // R9
        cen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr[7:4] == 4'd9 && wr_addr[3:0] == SEL_W'(o)
             && wr_data[SEL_W-1:0] != SEL_NONE) |=> clk_en[o]);
        // R9
        cen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[o] |=> clk_en[o]);
    end

endmodule

// File: rtl/mix_blend_unit.sv
module mix_blend_unit #(
    parameter int COMP_W  = 12,
    parameter int ALPHA_W = 8
) (
    input  logic [2:0][COMP_W-1:0] top_px,
    input  logic [2:0][COMP_W-1:0] bot_px,
    input  logic [ALPHA_W-1:0]     alpha,
    output logic [2:0][COMP_W-1:0] mix_px
);

    localparam int SUM_W = COMP_W + ALPHA_W + 1;
    localparam int AMAX  = (1 << ALPHA_W) - 1;

    logic [ALPHA_W-1:0] inv_a;
    assign inv_a = ALPHA_W'(AMAX) - alpha;

    for (genvar c = 0; c < 3; c++) begin : g_comp
        logic [SUM_W-1:0] acc;
        always_comb begin
            acc = SUM_W'(top_px[c]) * SUM_W'(alpha)
                + SUM_W'(bot_px[c]) * SUM_W'(inv_a)
                + SUM_W'(AMAX / 2);
            mix_px[c] = COMP_W'(acc / SUM_W'(AMAX));
        end

        always_comb begin
            // R5
            mix_range_chk: assert ((mix_px[c] >= top_px[c] || mix_px[c] >= bot_px[c])
                                && (mix_px[c] <= top_px[c] || mix_px[c] <= bot_px[c]));
        end
    end

endmodule

// File: rtl/mix_stage.sv
module mix_stage
    import mix_pkg::*;
#(
    parameter int NUM_PLANES = 4,
    parameter int NUM_STAGES = 4,
    parameter int COMP_W     = 12,
    parameter int ALPHA_W    = 8,
    parameter int SELF       = 0
) (
    input  logic [NUM_PLANES-1:0][3*COMP_W-1:0] plane_pix,
    input  logic [NUM_PLANES-1:0][ALPHA_W-1:0]  plane_alpha,
    input  logic [NUM_STAGES-1:0][3*COMP_W-1:0] lower_px,
    input  logic [SEL_W-1:0]                    top_sel,
    input  logic [SEL_W-1:0]                    bot_sel,
    input  logic [1:0]                          mode,
    input  logic [1:0]                          amode,
    input  logic [ALPHA_W-1:0]                  galpha,
    input  logic [3*COMP_W-1:0]                 bg_px,
    output logic [3*COMP_W-1:0]                 stage_px
);

    logic [3*COMP_W-1:0] top_px, bot_px;
    logic [ALPHA_W-1:0]  top_a;

    always_comb begin
        top_px = '0;
        top_a  = '0;
        for (int i = 0; i < NUM_PLANES; i++) begin
            if (top_sel == SEL_W'(i)) begin
                top_px = plane_pix[i];
                top_a  = (amode == AMODE_PIXEL) ? plane_alpha[i] : galpha;
            end
        end
    end

    always_comb begin
        bot_px = bg_px;
        if (mode == MODE_MIX) begin
            for (int i = 0; i < NUM_STAGES; i++) begin
                if (i != SELF && bot_sel == SEL_W'(i)) begin
                    bot_px = lower_px[i];
                end
            end
        end
    end

    mix_blend_unit #(
        .COMP_W  (COMP_W),
        .ALPHA_W (ALPHA_W)
    ) u_blend (
        .top_px (top_px),
        .bot_px (bot_px),
        .alpha  (top_a),
        .mix_px (stage_px)
    );

endmodule

// File: rtl/mix_idle_track.sv
module mix_idle_track
    import mix_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int NUM_OUTS   = 2
) (
    input  logic [NUM_OUTS-1:0][SEL_W-1:0]   mux_sel,
    input  logic [NUM_STAGES-1:0][SEL_W-1:0] owner,
    input  logic [NUM_STAGES-1:0][SEL_W-1:0] bot_sel,
    input  logic [NUM_STAGES-1:0][1:0]       mode,
    output logic [NUM_STAGES-1:0]            idle
);

    always_comb begin
        logic [NUM_STAGES-1:0] busy, reach, nxt;
        busy = '0;
        for (int o = 0; o < NUM_OUTS; o++) begin
            reach = '0;
            for (int s = 0; s < NUM_STAGES; s++) begin
                if (mux_sel[o] == SEL_W'(s)) reach[s] = 1'b1;
            end
            for (int step = 0; step < NUM_STAGES - 1; step++) begin
                nxt = reach;
                for (int s = 0; s < NUM_STAGES; s++) begin
                    if (reach[s] && mode[s] == MODE_MIX) begin
                        for (int t = 0; t < NUM_STAGES; t++) begin
                            if (t != s && bot_sel[s] == SEL_W'(t)) nxt[t] = 1'b1;
                        end
                    end
                end
                reach = nxt;
            end
            for (int s = 0; s < NUM_STAGES; s++) begin
                if (reach[s] && owner[s] == SEL_W'(o)) busy[s] = 1'b1;
            end
        end
        idle = ~busy;
    end

endmodule

// File: rtl/layer_mix_chain.sv
module layer_mix_chain
    import mix_pkg::*;
#(
    parameter int NUM_PLANES = 4,
    parameter int NUM_STAGES = 4,
    parameter int NUM_OUTS   = 2,
    parameter int COMP_W     = 12,
    parameter int IN_COMP_W  = 10,
    parameter int ALPHA_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [7:0]                     wr_addr,
    input  logic [IN_COMP_W-1:0]           wr_data,
    input  logic                           pix_valid,
    input  logic [NUM_PLANES*3*COMP_W-1:0] plane_pix,
    input  logic [NUM_PLANES*ALPHA_W-1:0]  plane_alpha,
    output logic                           out_valid,
    output logic [NUM_OUTS*3*COMP_W-1:0]   out_pix,
    output logic [NUM_OUTS-1:0]            out_clk_en,
    output logic [NUM_STAGES-1:0]          stage_idle
);

    localparam int PIX_W = 3 * COMP_W;

    logic [NUM_PLANES-1:0][PIX_W-1:0]   planes;
    logic [NUM_PLANES-1:0][ALPHA_W-1:0] alphas;
    assign planes = plane_pix;
    assign alphas = plane_alpha;

    logic [NUM_STAGES-1:0][SEL_W-1:0]   top_sel, bot_sel, owner;
    logic [NUM_STAGES-1:0][1:0]         mode, amode;
    logic [NUM_STAGES-1:0][ALPHA_W-1:0] galpha;
    logic [NUM_STAGES-1:0][PIX_W-1:0]   bg_px;
    logic [NUM_OUTS-1:0][SEL_W-1:0]     mux_sel;

    mix_cfg_regs #(
        .NUM_STAGES (NUM_STAGES),
        .NUM_OUTS   (NUM_OUTS),
        .COMP_W     (COMP_W),
        .IN_COMP_W  (IN_COMP_W),
        .ALPHA_W    (ALPHA_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .top_sel (top_sel),
        .bot_sel (bot_sel),
        .owner   (owner),
        .mode    (mode),
        .amode   (amode),
        .galpha  (galpha),
        .bg_px   (bg_px),
        .mux_sel (mux_sel),
        .clk_en  (out_clk_en)
    );

    mix_idle_track #(
        .NUM_STAGES (NUM_STAGES),
        .NUM_OUTS   (NUM_OUTS)
    ) u_idle (
        .mux_sel (mux_sel),
        .owner   (owner),
        .bot_sel (bot_sel),
        .mode    (mode),
        .idle    (stage_idle)
    );

    // Level p+1 of every stage sees level p of the others; level 0 is the backgrounds.
    logic [NUM_STAGES-1:0][PIX_W-1:0] lvl [NUM_STAGES+1];
    assign lvl[0] = bg_px;

    for (genvar p = 0; p < NUM_STAGES; p++) begin : g_lvl
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
            mix_stage #(
                .NUM_PLANES (NUM_PLANES),
                .NUM_STAGES (NUM_STAGES),
                .COMP_W     (COMP_W),
                .ALPHA_W    (ALPHA_W),
                .SELF       (s)
            ) u_stage (
                .plane_pix   (planes),
                .plane_alpha (alphas),
                .lower_px    (lvl[p]),
                .top_sel     (top_sel[s]),
                .bot_sel     (bot_sel[s]),
                .mode        (mode[s]),
                .amode       (amode[s]),
                .galpha      (galpha[s]),
                .bg_px       (bg_px[s]),
                .stage_px    (lvl[p+1][s])
            );
        end
    end

    typedef struct packed {
        logic                           vld;
        logic [NUM_OUTS-1:0][PIX_W-1:0] pix;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = pix_valid;
        if (pix_valid) begin
            for (int o = 0; o < NUM_OUTS; o++) begin
                st_d.pix[o] = '0;
                for (int s = 0; s < NUM_STAGES; s++) begin
                    if (mux_sel[o] == SEL_W'(s)) st_d.pix[o] = lvl[NUM_STAGES][s];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;

    // R8
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && $stable(out_pix)));

    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out_chk
        // R8
        none_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && mux_sel[o] >= SEL_W'(NUM_STAGES))
            |=> (out_pix[o*PIX_W +: PIX_W] == '0));
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_head
            // R10
            busy_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mux_sel[o] == SEL_W'(s) && owner[s] == SEL_W'(o)) |-> !stage_idle[s]);
        end
    end

endmodule

// File: tb/layer_mix_chain_bench.sv
module layer_mix_chain_bench;

    localparam int NP = 4, NS = 4, NO = 2, CW = 12, IW = 10, AW = 8;
    localparam int PW = 3 * CW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n, wr_en, pix_valid;
    logic [7:0]        wr_addr;
    logic [IW-1:0]     wr_data;
    logic [NP*PW-1:0]  plane_pix;
    logic [NP*AW-1:0]  plane_alpha;
    logic              out_valid;
    logic [NO*PW-1:0]  out_pix;
    logic [NO-1:0]     out_clk_en;
    logic [NS-1:0]     stage_idle;

    layer_mix_chain u_layer_mix_chain (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .pix_valid (pix_valid), .plane_pix (plane_pix),
        .plane_alpha (plane_alpha), .out_valid (out_valid), .out_pix (out_pix),
        .out_clk_en (out_clk_en), .stage_idle (stage_idle)
    );

    int vectors = 0, fails = 0;
    int m_top[NS], m_bot[NS], m_mode[NS], m_am[NS], m_ga[NS], m_own[NS];
    int m_bg[NS][3];
    int m_mux[NO], m_cen[NO];
    int p_pix[NP][3];
    int p_a[NP];
    int e_out[NO][3];

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_top[s] = 15; m_bot[s] = 15; m_own[s] = 15;
            m_mode[s] = 1; m_am[s] = 2; m_ga[s] = 255;
            for (int c = 0; c < 3; c++) m_bg[s][c] = 0;
        end
        for (int o = 0; o < NO; o++) begin
            m_mux[o] = 15; m_cen[o] = 0;
        end
        for (int p = 0; p < NP; p++) begin
            p_a[p] = 0;
            for (int c = 0; c < 3; c++) p_pix[p][c] = 0;
        end
    endtask

    task automatic wr(int kind, int idx, int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 8'(kind * 16 + idx);
        wr_data = IW'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (kind <= 8 && idx < NS) begin
            case (kind)
                0: m_top[idx] = data & 15;
                1: m_bot[idx] = data & 15;
                2: m_mode[idx] = data & 3;
                3: m_am[idx] = data & 3;
                4: m_ga[idx] = data & 255;
                5: m_bg[idx][0] = (data & 1023) << 2;
                6: m_bg[idx][1] = (data & 1023) << 2;
                7: m_bg[idx][2] = (data & 1023) << 2;
                default: m_own[idx] = data & 15;
            endcase
        end
        if (kind == 9 && idx < NO) begin
            m_mux[idx] = data & 15;
            if ((data & 15) != 15) m_cen[idx] = 1;
        end
    endtask

    function automatic int mixv(int t, int b, int a);
        return (t * a + b * (255 - a) + 127) / 255;
    endfunction

    task automatic compute_expected();
        int cur[NS][3];
        int nxt[NS][3];
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < 3; c++) cur[s][c] = m_bg[s][c];
        for (int lv = 0; lv < NS; lv++) begin
            for (int s = 0; s < NS; s++) begin
                int a, t, b;
                bit use_b;
                use_b = (m_mode[s] == 3) && (m_bot[s] < NS) && (m_bot[s] != s);
                for (int c = 0; c < 3; c++) begin
                    if (m_top[s] < NP) begin
                        t = p_pix[m_top[s]][c];
                        a = (m_am[s] == 0) ? p_a[m_top[s]] : m_ga[s];
                    end else begin
                        t = 0; a = 0;
                    end
                    b = use_b ? cur[m_bot[s]][c] : m_bg[s][c];
                    nxt[s][c] = mixv(t, b, a);
                end
            end
            cur = nxt;
        end
        for (int o = 0; o < NO; o++)
            for (int c = 0; c < 3; c++)
                e_out[o][c] = (m_mux[o] < NS) ? cur[m_mux[o]][c] : 0;
    endtask

    task automatic drive_planes();
        for (int p = 0; p < NP; p++) begin
            plane_alpha[p*AW +: AW] = AW'(p_a[p]);
            for (int c = 0; c < 3; c++)
                plane_pix[p*PW + (2 - c) * CW +: CW] = CW'(p_pix[p][c]);
        end
    endtask

    task automatic check_outs(string tag);
        for (int o = 0; o < NO; o++)
            for (int c = 0; c < 3; c++)
                chk(tag, int'(out_pix[o*PW + (2 - c) * CW +: CW]), e_out[o][c]);
    endtask

    task automatic apply_pixel(string tag);
        @(negedge clk);
        drive_planes();
        pix_valid = 1'b1;
        compute_expected();
        @(negedge clk);
        pix_valid = 1'b0;
        chk({tag, " valid"}, int'(out_valid), 1);
        check_outs(tag);
    endtask

    task automatic check_status(string tag);
        int busy[NS];
        for (int s = 0; s < NS; s++) busy[s] = 0;
        for (int o = 0; o < NO; o++) begin
            int reach[NS];
            for (int s = 0; s < NS; s++) reach[s] = (m_mux[o] == s) ? 1 : 0;
            for (int k = 0; k < NS; k++)
                for (int s = 0; s < NS; s++)
                    if (reach[s] == 1 && m_mode[s] == 3 && m_bot[s] < NS && m_bot[s] != s)
                        reach[m_bot[s]] = 1;
            for (int s = 0; s < NS; s++)
                if (reach[s] == 1 && m_own[s] == o) busy[s] = 1;
        end
        for (int s = 0; s < NS; s++) chk({tag, " R10 idle"}, int'(stage_idle[s]), 1 - busy[s]);
        for (int o = 0; o < NO; o++) chk({tag, " R9 clk_en"}, int'(out_clk_en[o]), m_cen[o]);
    endtask

    task automatic set_plane(int p, int r, int g, int b, int a);
        p_pix[p][0] = r; p_pix[p][1] = g; p_pix[p][2] = b; p_a[p] = a;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; pix_valid = 1'b0;
        wr_addr = '0; wr_data = '0; plane_pix = '0; plane_alpha = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_pix", (out_pix == '0) ? 1 : 0, 1);
        check_status("R1");
        apply_pixel("R8 no select gives zero");

        // R9: writing 0xF does not set the enable
        wr(9, 1, 15);
        check_status("R9 none write");

        // R3 R5 R7: top-only stage over background, full global alpha sweep
        wr(0, 0, 1); wr(5, 0, 1023); wr(6, 0, 512); wr(7, 0, 3);
        wr(9, 0, 0); wr(8, 0, 0);
        set_plane(1, 4095, 100, 2048, 0);
        for (int a = 0; a < 256; a++) begin
            wr(4, 0, a);
            apply_pixel("R5 R7 global alpha sweep");
        end
        check_status("R10 single stage");

        // R6: per-pixel alpha
        wr(3, 0, 0);
        for (int a = 0; a < 256; a += 5) begin
            set_plane(1, a * 16, 4095 - a * 16, a, a);
            apply_pixel("R6 per-pixel alpha");
        end
        wr(3, 0, 1);
        apply_pixel("R6 other code takes global alpha");

        // R4 R11 R10: full chains in every rotation of stage indices
        for (int r = 0; r < NS; r++) begin
            for (int k = 0; k < NS; k++) begin
                int s;
                s = (r + k) % NS;
                wr(0, s, k);
                wr(1, s, (k < NS - 1) ? (r + k + 1) % NS : 15);
                wr(2, s, (k < NS - 1) ? 3 : 1);
                wr(3, s, 2);
                wr(4, s, 60 + 50 * k);
                wr(5, s, 100 * k + r); wr(6, s, 1000 - 90 * k); wr(7, s, 37 * k);
                wr(8, s, (k == NS - 1) ? 1 : 0);
            end
            wr(9, 0, r);
            wr(9, 1, (r + 2) % NS);
            check_status("R11 chain");
            for (int v = 0; v < 4; v++) begin
                for (int p = 0; p < NP; p++)
                    set_plane(p, (v * 977 + p * 300) % 4096, (v * 131 + p * 1100) % 4096,
                              4095 - (v * 400 + p * 51) % 4096, 0);
                apply_pixel("R4 R11 chain blend");
            end
        end

        // R4: self link, out-of-range link, top-only with a link
        wr(1, 3, 3);
        apply_pixel("R4 self bottom uses background");
        wr(1, 3, 14);
        apply_pixel("R4 out-of-range bottom uses background");
        wr(1, 3, 0); wr(2, 3, 1);
        apply_pixel("R4 top-only ignores bottom link");
        check_status("R10 broken chain");

        // R11: two-stage link cycle
        wr(2, 3, 3); wr(1, 0, 3); wr(2, 0, 3);
        apply_pixel("R11 link cycle");

        // R3: disconnected top
        wr(0, 3, 15);
        apply_pixel("R3 no top plane");

        // R2: out-of-range instance writes have no effect
        wr(0, 9, 2);
        wr(9, 3, 1);
        apply_pixel("R2 out-of-range instance");
        check_status("R2 status");

        // R8: hold while pix_valid is low
        @(negedge clk);
        set_plane(0, 1, 2, 3, 4);
        drive_planes();
        @(negedge clk);
        chk("R8 hold valid", int'(out_valid), 0);
        check_outs("R8 hold pixels");

        // R8: out-of-range output select; R9: sticky enable
        wr(9, 1, 7);
        apply_pixel("R8 out-of-range select gives zero");
        wr(9, 1, 15);
        check_status("R9 sticky after none write");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule